// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in, with no clock. It returns a 16-bit sum and a carry-out. The operand width is split into four 4-bit groups. Each group builds a generate term (AND) and a propagate term (OR) for every bit. From these it works out all of its internal carries at once, each as a flat sum of products of the generate terms, the propagate terms and the group's carry-in. Each group also reports one group-generate and one group-propagate signal.

A second lookahead unit of the same form takes these group signals and the external carry-in. From them it produces the carry into every upper group and the final carry-out. No carry ripples from one group to the next, so the logic depth stays fixed whatever carry chain the operands produce. The block fits wherever a datapath needs a fast unsigned add with the carry out exposed.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + carry_in`, taken as unsigned values.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned result of `a_in + b_in + carry_in`.
- R3: With `a_in` = 0xFFFF, `b_in` = 0x0001 and `carry_in` = 0, the outputs are `sum_out` = 0x0000 and `carry_out` = 1.
- R4: With both operands 0xFFFF and `carry_in` = 1, the outputs are `sum_out` = 0xFFFF and `carry_out` = 1.
- R5: With both operands zero, `sum_out` equals `carry_in` zero-extended to 16 bits, and `carry_out` is 0.
- R6: The carry entering group k (bits 4k to 4k+3, k = 1..3) equals the carry out of the unsigned addition of operand bits 0 to 4k-1 plus `carry_in`. A carry that starts in bit 0 therefore reaches bit 4, 8, 12 or 15. Examples: 0x000F+1 = 0x0010, 0x00FF+1 = 0x0100, 0x0FFF+1 = 0x1000, 0x7FFF+1 = 0x8000.
- R7: When `b_in` is the bitwise complement of `a_in`, the result is 0xFFFF with `carry_out` = 0 if `carry_in` = 0. It is 0x0000 with `carry_out` = 1 if `carry_in` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Random operand pairs with both carry-in values test the general sum and carry-out against a 17-bit reference addition. Carry chains that start at bit 0 and end at each group boundary show whether the second-level carries are right for each group. A flaw in one group carry term shows up only at its own boundary. Operands that are complements of each other make every bit propagate without generating. All-ones operands make every bit generate. Zero operands make nothing happen. These three patterns separate a wrong group-propagate term from a wrong group-generate term.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int GRP_W   = 4;
    localparam int NUM_GRP = 4;
    localparam int DATA_W  = GRP_W * NUM_GRP;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;

    function automatic logic [DATA_W:0] ref_add(input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y,
                                                input logic             ci);
        return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_in,
    input  logic [N-1:0] prop_in,
    input  logic         c0,
    output logic [N-1:0] carries,
    output cla_pkg::gp_pair_t group_gp
);
    always_comb begin
        for (int k = 0; k < N; k++) begin
            logic acc;
            logic term;
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = gen_in[j];
                for (int m = j + 1; m < k; m++) term = term & prop_in[m];
                acc = acc | term;
            end
            term = c0;
            for (int m = 0; m < k; m++) term = term & prop_in[m];
            carries[k] = acc | term;
        end
    end

    always_comb begin
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = gen_in[j];
            for (int m = j + 1; m < N; m++) term = term & prop_in[m];
            acc = acc | term;
        end
        group_gp.gen  = acc;
        group_gp.prop = &prop_in;
    end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output cla_pkg::gp_pair_t gp
);
    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_carry;

    assign bit_gen  = a & b;
    assign bit_prop = a | b;

    cla_lookahead #(.N(W)) u_la (
        .gen_in   (bit_gen),
        .prop_in  (bit_prop),
        .c0       (cin),
        .carries  (bit_carry),
        .group_gp (gp)
    );

    assign sum = a ^ b ^ bit_carry;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
(
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    gp_pair_t           grp_gp [NUM_GRP];
    logic [NUM_GRP-1:0] grp_gen;
    logic [NUM_GRP-1:0] grp_prop;
    logic [NUM_GRP-1:0] grp_cin;
    gp_pair_t           top_gp;

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        cla_group #(.W(GRP_W)) u_grp (
            .a   (a_in[k*GRP_W +: GRP_W]),
            .b   (b_in[k*GRP_W +: GRP_W]),
            .cin (grp_cin[k]),
            .sum (sum_out[k*GRP_W +: GRP_W]),
            .gp  (grp_gp[k])
        );
        assign grp_gen[k]  = grp_gp[k].gen;
        assign grp_prop[k] = grp_gp[k].prop;
    end

    cla_lookahead #(.N(NUM_GRP)) u_second (
        .gen_in   (grp_gen),
        .prop_in  (grp_prop),
        .c0       (carry_in),
        .carries  (grp_cin),
        .group_gp (top_gp)
    );

    assign carry_out = top_gp.gen | (top_gp.prop & carry_in);
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk
    import cla_pkg::*;
(
    input logic [DATA_W-1:0]  a_in,
    input logic [DATA_W-1:0]  b_in,
    input logic               carry_in,
    input logic [DATA_W-1:0]  sum_out,
    input logic               carry_out,
    input logic [NUM_GRP-1:0] grp_cin
);
    logic [DATA_W:0] expect_full;
    logic            known;

    assign expect_full = ref_add(a_in, b_in, carry_in);
    assign known = !$isunknown({a_in, b_in, carry_in, sum_out, carry_out, grp_cin});

    always_comb begin
        if (known) begin
            AST_SUM_MATCH: assert (sum_out == expect_full[DATA_W-1:0]) else $error("sum mismatch"); // R1
            AST_COUT_MATCH: assert (carry_out == expect_full[DATA_W]) else $error("carry mismatch"); // R2
            if (a_in == {DATA_W{1'b1}} && b_in == 1 && !carry_in)
                AST_ONES_PLUS_ONE: assert (sum_out == 0 && carry_out) else $error("ones+1"); // R3
            if (a_in == {DATA_W{1'b1}} && b_in == {DATA_W{1'b1}} && carry_in)
                AST_ONES_ONES: assert (sum_out == {DATA_W{1'b1}} && carry_out) else $error("ones+ones"); // R4
            if (a_in == 0 && b_in == 0)
                AST_ZERO_OPERANDS: assert (sum_out == {{(DATA_W-1){1'b0}}, carry_in} && !carry_out) else $error("zero"); // R5
            if (b_in == ~a_in)
                AST_COMPLEMENT: assert (carry_out == carry_in && sum_out == {DATA_W{~carry_in}}) else $error("complement"); // R7
        end
    end

    for (genvar k = 1; k < NUM_GRP; k++) begin : g_grp_chk
        localparam int LW = k * GRP_W;
        logic [LW:0] low_sum;
        assign low_sum = {1'b0, a_in[LW-1:0]} + {1'b0, b_in[LW-1:0]} + {{LW{1'b0}}, carry_in};
        always_comb begin
            if (known)
                AST_GROUP_CARRY: assert (grp_cin[k] == low_sum[LW]) else $error("group carry"); // R6
        end
    end
endmodule

bind cla16_adder cla16_adder_chk u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .grp_cin   (grp_cin)
);

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
    import cla_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  N_RANDOM   = 2000;

    typedef struct {
        logic [DATA_W-1:0] exp_sum;
        logic              exp_cout;
        string             tag;
    } item_t;

    logic              clk = 1'b0;
    logic [DATA_W-1:0] a_in = '0;
    logic [DATA_W-1:0] b_in = '0;
    logic              carry_in = 1'b0;
    logic [DATA_W-1:0] sum_out;
    logic              carry_out;

    item_t queue_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla16_adder uut (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    task automatic drive(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                         input logic ci, input string tag);
        item_t it;
        logic [DATA_W:0] full;
        @(posedge clk);
        a_in = a;
        b_in = b;
        carry_in = ci;
        full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
        it.exp_sum  = full[DATA_W-1:0];
        it.exp_cout = full[DATA_W];
        it.tag      = tag;
        queue_q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            n_checks++;
            if (sum_out !== it.exp_sum) begin
                n_fail++;
                $display("FAIL %s/R1 sum: actual %h expected %h", it.tag, sum_out, it.exp_sum);
            end
            n_checks++;
            if (carry_out !== it.exp_cout) begin
                n_fail++;
                $display("FAIL %s/R2 carry_out: actual %b expected %b", it.tag, carry_out, it.exp_cout);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive(16'h0000, 16'h0000, 1'b0, "R5");
        drive(16'h0000, 16'h0000, 1'b1, "R5");
        drive(16'hFFFF, 16'h0001, 1'b0, "R3");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R4");
        drive(16'hFFFF, 16'hFFFF, 1'b0, "R4");
        drive(16'h000F, 16'h0001, 1'b0, "R6");
        drive(16'h00FF, 16'h0001, 1'b0, "R6");
        drive(16'h0FFF, 16'h0001, 1'b0, "R6");
        drive(16'h7FFF, 16'h0001, 1'b0, "R6");
        drive(16'h00FF, 16'h0000, 1'b1, "R6");
        drive(16'h0F0F, 16'h00F0, 1'b1, "R6");
        drive(16'hAAAA, 16'h5555, 1'b0, "R7");
        drive(16'hAAAA, 16'h5555, 1'b1, "R7");
        drive(16'h1234, 16'hEDCB, 1'b1, "R7");
        for (int i = 0; i < N_RANDOM; i++) begin
            drive(DATA_W'($urandom), DATA_W'($urandom), 1'($urandom), "R1");
        end
        while (queue_q.size() > 0) @(posedge clk);
        @(posedge clk);
        finish_run();
    end
endmodule